// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Port Model

This block reproduces, in a single system-clock domain, the digital serial port of a multi-channel delta-sigma converter. It steps through three phases: converting, asleep with a result waiting, and shifting a 32-bit frame out on the data output while a 32-bit configuration word is shifted in on the data input. An external strobe marks the end of each conversion and supplies the result bits. Every pin is passed through a two-flop synchronizer, and pin edges are found by comparing each synchronized level with its value one cycle earlier.

Two serial clock modes are supported, and the mode is chosen again at every falling edge of the active-low chip select. If the clock pin is low at that moment, the host supplies the serial clock. If the pin is high, which is what a weak pull-up gives on an undriven pin, the block drives the clock line low. After a fixed wait it generates the clock itself. The wait is one of two parameters, picked by the oscillator-select pin.

The state machine has five states. CONVERT becomes SLEEP on the done strobe when chip select is high. CONVERT becomes EXT_SHIFT or INT_WAIT on the done strobe when chip select is already low. SLEEP becomes EXT_SHIFT or INT_WAIT on a chip-select fall. INT_WAIT becomes INT_SHIFT on the first generated rising edge. EXT_SHIFT and INT_SHIFT return to CONVERT on the 32nd falling edge. EXT_SHIFT, INT_WAIT and INT_SHIFT go back to SLEEP when chip select rises, and the result is kept.

Top module: `delsig_serial_port`

## Requirements
- R1: While the synchronized chip select is high, `sdo_oe` is 0.
- R2: While chip select is low during a conversion, `sdo_oe` is 1 and `sdo_out` is 1.
- R3: A `conv_done` pulse during a conversion captures `conv_result` (31 bits). The frame becomes {1'b0, conv_result}, and its bit 31 is the end-of-conversion status, 0 meaning a result is ready. With chip select low in this state, `sdo_out` shows 0.
- R4: The frame is sent MSB first. Before the (k+1)-th falling serial clock edge, `sdo_out` carries frame bit 31-k. The output moves to the next bit only after a falling edge.
- R5: `sdi_pin` is sampled on each rising serial clock edge, MSB first. After the 32nd rising edge, `rx_word` holds the 32 sampled bits and `rx_valid` pulses high for exactly one cycle.
- R6: After the 32nd falling edge, a new conversion starts. `sdo_out` returns to 1 and `sck_oe` is 0.
- R7: The clock mode is chosen at each chip-select fall. If the clock pin is high, the block sets `sck_oe` to 1 with `sck_out` low. If the pin is low, `sck_oe` stays 0 and the host clocks the port.
- R8: In internal mode, the first rising edge of `sck_out` comes exactly WAIT_INT cycles (`osc_sel`=0) or WAIT_EXT cycles (`osc_sel`=1) after `sck_oe` rises. Each high phase then lasts SCK_HALF cycles.
- R9: If chip select rises in internal mode before the first generated rising edge, the block returns to sleep, releases `sck_oe`, and keeps the result for a later readout.
- R10: A `conv_done` pulse outside a conversion is ignored: the frame held for readout is unchanged.
- R11: If a conversion completes while chip select is still low, readout starts at once in the mode latched at the last chip-select fall, and `sdo_out` falls from 1 to 0.
- R12: After reset the block is converting, with `sdo_oe`, `sck_oe` and `rx_valid` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csn_pin | input | 1 | Chip select pin, active low |
| sdi_pin | input | 1 | Serial data input pin |
| sck_pin_in | input | 1 | Level seen on the serial clock pin (high when undriven) |
| osc_sel | input | 1 | Oscillator select: 0 picks WAIT_INT, 1 picks WAIT_EXT |
| conv_done | input | 1 | One-cycle strobe marking the end of a conversion |
| conv_result | input | FRAME_W-1 | Result bits placed below the status bit |
| sdo_out | output | 1 | Serial data output value |
| sdo_oe | output | 1 | Output enable for the serial data pin |
| sck_out | output | 1 | Serial clock value driven in internal mode |
| sck_oe | output | 1 | Output enable for the serial clock pin |
| rx_word | output | FRAME_W | Last configuration word captured from the data input |
| rx_valid | output | 1 | One-cycle pulse when rx_word is updated |

## Verification
External-clock readouts are swept over walking-one results and walking-zero input words, plus a few dense patterns. A stuck, swapped or shifted-by-one bit on either the output or the capture path therefore shows up at its own bit position. Internal-mode frames are run once with each oscillator selection, and the measured wait before the first generated edge tells the two wait parameters apart. An aborted internal readout is followed by a stray done strobe and then an external readout; this separates result retention from result overwrite. A frame with chip select held low through the next conversion checks the path from conversion to immediate readout.

// File: rtl/adcsp_pkg.sv
package adcsp_pkg;

    typedef enum logic [2:0] {
        ST_CONVERT,
        ST_SLEEP,
        ST_EXT_SHIFT,
        ST_INT_WAIT,
        ST_INT_SHIFT
    } port_state_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_WAIT,
        PH_RUN
    } sck_phase_t;

endpackage

// File: rtl/adcsp_sync.sv
module adcsp_sync #(
    parameter int             N       = 4,
    parameter logic [N-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    logic [N-1:0] stage1;

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage1[i] <= RST_VAL[i];
                    q[i]      <= RST_VAL[i];
                end else begin
                    stage1[i] <= d[i];
                    q[i]      <= stage1[i];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/adcsp_sck_gen.sv
module adcsp_sck_gen
    import adcsp_pkg::*;
#(
    parameter int HALF  = 4,
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             active,
    input  logic [CNT_W-1:0] wait_len,
    output logic             sck_lvl,
    output logic             rise_p,
    output logic             fall_p
);

    localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(HALF - 1);

    sck_phase_t       phase;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            sck_lvl <= 1'b0;
            rise_p  <= 1'b0;
            fall_p  <= 1'b0;
        end else begin
            rise_p <= 1'b0;
            fall_p <= 1'b0;
            if (!active) begin
                phase   <= PH_IDLE;
                cnt     <= '0;
                sck_lvl <= 1'b0;
            end else if (arm) begin
                phase   <= PH_WAIT;
                cnt     <= wait_len - 1'b1;
                sck_lvl <= 1'b0;
            end else begin
                unique case (phase)
                    PH_IDLE: begin
                        cnt <= '0;
                    end
                    PH_WAIT: begin
                        if (cnt == '0) begin
                            phase   <= PH_RUN;
                            sck_lvl <= 1'b1;
                            rise_p  <= 1'b1;
                            cnt     <= HALF_M1;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    PH_RUN: begin
                        if (cnt == '0) begin
                            sck_lvl <= !sck_lvl;
                            rise_p  <= !sck_lvl;
                            fall_p  <= sck_lvl;
                            cnt     <= HALF_M1;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    // R7: the clock line stays low for the whole wait after chip select falls
    a_r7_low_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WAIT) |-> !sck_lvl);

    // R8: a single generated edge per cycle, never both directions at once
    a_r8_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_p && fall_p));

endmodule

// File: rtl/adcsp_shifter.sv
module adcsp_shifter #(
    parameter int FRAME_W = 32,
    parameter int BIT_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-2:0] load_val,
    input  logic               rise,
    input  logic               fall,
    input  logic               sdi,
    output logic               tx_msb,
    output logic               last_fall,
    output logic [FRAME_W-1:0] rx_word,
    output logic               rx_valid
);

    localparam logic [BIT_W-1:0] LAST = BIT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] tx_sr;
    logic [FRAME_W-2:0] rx_sr;
    logic [BIT_W-1:0]   rcnt;
    logic [BIT_W-1:0]   fcnt;

    assign tx_msb    = tx_sr[FRAME_W-1];
    assign last_fall = fall && (fcnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr    <= '0;
            rx_sr    <= '0;
            rcnt     <= '0;
            fcnt     <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else if (load) begin
            tx_sr    <= {1'b0, load_val};
            rcnt     <= '0;
            fcnt     <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (rise) begin
                rx_sr <= {rx_sr[FRAME_W-3:0], sdi};
                if (rcnt == LAST) begin
                    rx_word  <= {rx_sr, sdi};
                    rx_valid <= 1'b1;
                    rcnt     <= '0;
                end else begin
                    rcnt <= rcnt + 1'b1;
                end
            end
            if (fall) begin
                tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
                fcnt  <= (fcnt == LAST) ? '0 : fcnt + 1'b1;
            end
        end
    end

    // R5: a captured word only ever follows a rising clock edge
    a_r5_valid_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(rise));

    // R4: the outgoing frame holds still between falling edges
    a_r4_hold_between_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !load) |=> $stable(tx_sr));

endmodule

// File: rtl/delsig_serial_port.sv
module delsig_serial_port
    import adcsp_pkg::*;
#(
    parameter int FRAME_W  = 32,
    parameter int WAIT_INT = 1200,
    parameter int WAIT_EXT = 36,
    parameter int SCK_HALF = 50
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csn_pin,
    input  logic               sdi_pin,
    input  logic               sck_pin_in,
    input  logic               osc_sel,
    input  logic               conv_done,
    input  logic [FRAME_W-2:0] conv_result,
    output logic               sdo_out,
    output logic               sdo_oe,
    output logic               sck_out,
    output logic               sck_oe,
    output logic [FRAME_W-1:0] rx_word,
    output logic               rx_valid
);

    localparam int WMAX0 = (WAIT_INT > WAIT_EXT) ? WAIT_INT : WAIT_EXT;
    localparam int WMAX  = (WMAX0 > SCK_HALF) ? WMAX0 : SCK_HALF;
    localparam int CNT_W = $clog2(WMAX + 1);
    localparam int BIT_W = $clog2(FRAME_W);

    // synchronized pins: {osc, sck, sdi, csn}
    logic [3:0] pins_s;
    logic       cs_s, sdi_s, sck_s, osc_s;

    adcsp_sync #(.N(4), .RST_VAL(4'b0101)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({osc_sel, sck_pin_in, sdi_pin, csn_pin}),
        .q     (pins_s)
    );

    assign cs_s  = pins_s[0];
    assign sdi_s = pins_s[1];
    assign sck_s = pins_s[2];
    assign osc_s = pins_s[3];

    logic cs_q, sck_q;
    logic cs_fall, cs_rise, sck_rise, sck_fall;

    assign cs_fall  = cs_q && !cs_s;
    assign cs_rise  = !cs_q && cs_s;
    assign sck_rise = !sck_q && sck_s;
    assign sck_fall = sck_q && !sck_s;

    port_state_t        state, state_d;
    logic               mode_q, mode_now;
    logic [FRAME_W-2:0] res_q;

    logic               arm, gen_active, gen_lvl, gen_rise, gen_fall;
    logic               sh_load, sh_rise, sh_fall, tx_msb, last_fall;
    logic [FRAME_W-2:0] load_val;
    logic [CNT_W-1:0]   wait_len;
    logic               in_int, abort;

    assign mode_now = cs_fall ? sck_s : mode_q;
    assign in_int   = (state == ST_INT_WAIT) || (state == ST_INT_SHIFT);
    assign abort    = cs_rise && (in_int || (state == ST_EXT_SHIFT));
    assign wait_len = osc_s ? CNT_W'(WAIT_EXT) : CNT_W'(WAIT_INT);

    // next-state decision
    always_comb begin
        state_d = state;
        unique case (state)
            ST_CONVERT: begin
                if (conv_done) begin
                    if (!cs_s) state_d = mode_now ? ST_INT_WAIT : ST_EXT_SHIFT;
                    else       state_d = ST_SLEEP;
                end
            end
            ST_SLEEP: begin
                if (cs_fall) state_d = sck_s ? ST_INT_WAIT : ST_EXT_SHIFT;
            end
            ST_EXT_SHIFT: begin
                if (cs_rise)        state_d = ST_SLEEP;
                else if (last_fall) state_d = ST_CONVERT;
            end
            ST_INT_WAIT: begin
                if (cs_rise)       state_d = ST_SLEEP;
                else if (gen_rise) state_d = ST_INT_SHIFT;
            end
            ST_INT_SHIFT: begin
                if (cs_rise)        state_d = ST_SLEEP;
                else if (last_fall) state_d = ST_CONVERT;
            end
            default: state_d = ST_CONVERT;
        endcase
    end

    // state register and pin history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_CONVERT;
            cs_q   <= 1'b1;
            sck_q  <= 1'b1;
            mode_q <= 1'b1;
            res_q  <= '0;
        end else begin
            state <= state_d;
            cs_q  <= cs_s;
            sck_q <= sck_s;
            if (cs_fall) mode_q <= sck_s;
            if ((state == ST_CONVERT) && conv_done) res_q <= conv_result;
        end
    end

    // outputs and datapath controls
    always_comb begin
        sdo_oe     = !cs_s;
        sdo_out    = (state == ST_CONVERT) ? 1'b1 : tx_msb;
        sck_oe     = in_int;
        arm        = (state_d == ST_INT_WAIT) && (state != ST_INT_WAIT);
        gen_active = arm || in_int;
        sh_load    = ((state == ST_CONVERT) && conv_done) || abort;
        load_val   = (state == ST_CONVERT) ? conv_result : res_q;
        sh_rise    = ((state == ST_EXT_SHIFT) && sck_rise) || (in_int && gen_rise);
        sh_fall    = ((state == ST_EXT_SHIFT) && sck_fall) || (in_int && gen_fall);
    end

    adcsp_sck_gen #(.HALF(SCK_HALF), .CNT_W(CNT_W)) u_sck_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .active   (gen_active),
        .wait_len (wait_len),
        .sck_lvl  (gen_lvl),
        .rise_p   (gen_rise),
        .fall_p   (gen_fall)
    );

    assign sck_out = gen_lvl;

    adcsp_shifter #(.FRAME_W(FRAME_W), .BIT_W(BIT_W)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_val  (load_val),
        .rise      (sh_rise),
        .fall      (sh_fall),
        .sdi       (sdi_s),
        .tx_msb    (tx_msb),
        .last_fall (last_fall),
        .rx_word   (rx_word),
        .rx_valid  (rx_valid)
    );

    // R6: the final falling edge of a frame restarts conversion
    a_r6_restart_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (last_fall && !cs_rise) |=> (state == ST_CONVERT && !sck_oe));

    // R9: releasing chip select during the wait returns to sleep
    a_r9_abort_to_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INT_WAIT && cs_rise) |=> (state == ST_SLEEP && !sck_oe));

    // R10: a stray done strobe leaves the held result alone
    a_r10_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_CONVERT && conv_done) |=> $stable(res_q));

    // R7: the block takes the clock line with it held low
    a_r7_take_line_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_oe) |-> !sck_out);

    // R11: conversion ending under a low chip select goes straight to readout
    a_r11_direct_readout: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONVERT && conv_done && !cs_s)
        |=> (state == ST_EXT_SHIFT || state == ST_INT_WAIT));

endmodule

// File: tb/test_delsig_serial_port.sv
module test_delsig_serial_port;

    localparam int FW = 32;
    localparam int WI = 20;
    localparam int WE = 12;
    localparam int HF = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          csn   = 1'b1;
    logic          sdi   = 1'b0;
    logic          sckp  = 1'b1;
    logic          osc   = 1'b0;
    logic          done  = 1'b0;
    logic [FW-2:0] res   = '0;

    logic          sdo_out, sdo_oe, sck_out, sck_oe, rx_valid;
    logic [FW-1:0] rx_word;

    int n_chk = 0;
    int n_err = 0;
    int vcnt  = 0;
    bit finished = 1'b0;

    delsig_serial_port #(
        .FRAME_W (FW),
        .WAIT_INT(WI),
        .WAIT_EXT(WE),
        .SCK_HALF(HF)
    ) i_delsig_serial_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .csn_pin    (csn),
        .sdi_pin    (sdi),
        .sck_pin_in (sckp),
        .osc_sel    (osc),
        .conv_done  (done),
        .conv_result(res),
        .sdo_out    (sdo_out),
        .sdo_oe     (sdo_oe),
        .sck_out    (sck_out),
        .sck_oe     (sck_oe),
        .rx_word    (rx_word),
        .rx_valid   (rx_valid)
    );

    always @(posedge clk) if (rx_valid) vcnt <= vcnt + 1;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic pulse_done(input logic [FW-2:0] v);
        done = 1'b1;
        res  = v;
        step(1);
        done = 1'b0;
        step(2);
    endtask

    task automatic wait_oe();
        int n = 0;
        while (!sck_oe && n < 1000) begin step(1); n++; end
    endtask

    // host-clocked frame; chip select already low with the clock pin low
    task automatic ext_frame(input logic [FW-2:0] r, input logic [31:0] w,
                             output logic [31:0] got);
        logic [31:0] fr;
        int v0;
        fr  = {1'b0, r};
        v0  = vcnt;
        got = '0;
        for (int k = 0; k < 32; k++) begin
            sdi = w[31-k];
            step(8);
            sckp = 1'b1;
            step(8);
            got = {got[30:0], sdo_out};
            chk("R4 external bit", {31'd0, sdo_out}, {31'd0, fr[31-k]});
            if (k == 0) chk("R7 host clock keeps line released", {31'd0, sck_oe}, 32'd0);
            sckp = 1'b0;
            step(8);
        end
        chk("R6 status high after frame", {31'd0, sdo_out}, 32'd1);
        chk("R5 captured word", rx_word, w);
        chk("R5 single valid pulse", vcnt - v0, 32'd1);
    endtask

    // self-clocked frame; chip select high on entry and on exit
    task automatic int_frame(input logic [FW-2:0] r, input logic [31:0] w,
                             input logic o, input int expw);
        logic [31:0] fr;
        int n;
        int v0;
        fr   = {1'b0, r};
        v0   = vcnt;
        osc  = o;
        sckp = 1'b1;
        sdi  = w[31];
        step(6);
        csn = 1'b0;
        wait_oe();
        chk("R7 internal mode takes line", {31'd0, sck_oe}, 32'd1);
        chk("R7 line starts low", {31'd0, sck_out}, 32'd0);
        n = 0;
        while (!sck_out && n < 5000) begin step(1); n++; end
        chk("R8 wait before first edge", n, expw);
        for (int k = 0; k < 32; k++) begin
            chk("R4 internal bit", {31'd0, sdo_out}, {31'd0, fr[31-k]});
            n = 0;
            while (sck_out && n < 5000) begin step(1); n++; end
            if (k == 0) chk("R8 high phase length", n, HF);
            if (k < 31) begin
                sdi = w[30-k];
                n = 0;
                while (!sck_out && n < 5000) begin step(1); n++; end
            end
        end
        step(6);
        chk("R6 line released after frame", {31'd0, sck_oe}, 32'd0);
        chk("R6 status high after frame", {31'd0, sdo_out}, 32'd1);
        chk("R5 captured word internal", rx_word, w);
        chk("R5 single valid pulse internal", vcnt - v0, 32'd1);
        csn = 1'b1;
        step(6);
    endtask

    initial begin
        logic [31:0] got;
        logic [30:0] rv [4];
        logic [31:0] wv [4];
        rv = '{31'h5A5A_3C3C, 31'h7FFF_FFFF, 31'h2AAA_AAAA, 31'h0000_0001};
        wv = '{32'hA5A5_C3C3, 32'h0000_0000, 32'h5555_5555, 32'hFFFF_FFFF};

        step(3);
        rst_n = 1'b1;
        step(2);
        chk("R12 sdo_oe after reset", {31'd0, sdo_oe}, 32'd0);
        chk("R12 sck_oe after reset", {31'd0, sck_oe}, 32'd0);
        chk("R12 rx_valid after reset", {31'd0, rx_valid}, 32'd0);

        csn  = 1'b0;
        sckp = 1'b0;
        step(6);
        chk("R2 output driven while converting", {31'd0, sdo_oe}, 32'd1);
        chk("R2 status busy", {31'd0, sdo_out}, 32'd1);
        csn = 1'b1;
        step(6);
        chk("R1 output released", {31'd0, sdo_oe}, 32'd0);

        for (int i = 0; i < 4; i++) begin
            pulse_done(rv[i]);
            chk("R1 released in sleep", {31'd0, sdo_oe}, 32'd0);
            csn = 1'b0;
            step(6);
            chk("R3 ready status", {31'd0, sdo_out}, 32'd0);
            ext_frame(rv[i], wv[i], got);
            chk("R3 frame content", got, {1'b0, rv[i]});
            csn = 1'b1;
            step(6);
            chk("R1 released after frame", {31'd0, sdo_oe}, 32'd0);
        end

        for (int i = 0; i < 31; i++) begin
            pulse_done(31'd1 << i);
            csn = 1'b0;
            step(6);
            ext_frame(31'd1 << i, ~(32'd1 << i), got);
            chk("R3 walking-one frame", got, {1'b0, 31'd1 << i});
            csn = 1'b1;
            step(6);
        end

        pulse_done(31'h1234_5678);
        int_frame(31'h1234_5678, 32'hDEAD_BEEF, 1'b0, WI);
        pulse_done(31'h6BCD_0F0F);
        int_frame(31'h6BCD_0F0F, 32'h0F1E_2D3C, 1'b1, WE);

        pulse_done(31'h3333_CCCC);
        osc  = 1'b0;
        sckp = 1'b1;
        step(4);
        csn = 1'b0;
        wait_oe();
        step(5);
        csn = 1'b1;
        step(8);
        chk("R9 line released on abort", {31'd0, sck_oe}, 32'd0);
        chk("R9 output released on abort", {31'd0, sdo_oe}, 32'd0);
        pulse_done(31'h0F0F_F0F0);
        sckp = 1'b0;
        step(2);
        csn = 1'b0;
        step(6);
        chk("R10 still ready after stray strobe", {31'd0, sdo_out}, 32'd0);
        ext_frame(31'h3333_CCCC, 32'h8000_0001, got);
        chk("R9 result kept after abort", got, {1'b0, 31'h3333_CCCC});
        chk("R10 stray result not loaded", got, {1'b0, 31'h3333_CCCC});

        step(6);
        chk("R11 busy with select low", {31'd0, sdo_out}, 32'd1);
        pulse_done(31'h4242_1818);
        chk("R11 ready at once", {31'd0, sdo_out}, 32'd0);
        ext_frame(31'h4242_1818, 32'h1357_9BDF, got);
        chk("R11 direct readout frame", got, {1'b0, 31'h4242_1818});
        csn = 1'b1;
        step(6);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule